// File: doc/BRIEF.md
# Byte-Selectable Host Register Bus Interface

This block is the host-facing register port of a 16-bit peripheral. A host places a 3-bit register address, chip select, byte/word mode and a read/write direction on the bus. It then pulses an asynchronous bus strobe. The block brings the strobe into the system clock domain through a synchronizer and detects both of its edges. It performs the access on the leading edge and applies read side effects on the trailing edge. The bidirectional data bus is split into an input, an output and an output enable for a pad cell outside the block.

Four 16-bit register words sit behind the port:
- Word 0 holds a received byte in its low half and a receive status byte in its high half. The serial receiver fills both halves.
- Word 1 holds the transmit data and control word. The serial transmitter drains it.
- Word 2 is a general control word.
- Word 3 is a read-only flag word.

A byte access reaches only one half of a word. Read data for a byte access appears on the lane of that half, and the other lane reads as zero. The flags follow the host accesses. Reading the receive halves clears their "available" flags when the strobe ends. Writing the transmit word clears the "buffer empty" flag. The serial engines themselves are outside this block and connect through the internal register ports.

Top module: `hbi_bus_if`

## Requirements
- R1: Synchronous reset clears every register word, all three flags, the read data output and the output enable to zero.
- R2: Address bits [2:1] select the word: 0 = receive (low byte data, high byte status), 1 = transmit, 2 = control, 3 = flags. Address bit 0 = 1 selects the high half. In the flag word, bit 0 = receive data available, bit 1 = receive status available and bit 2 = transmit buffer empty; all other bits read as zero.
- R3: A read with byte mode 0 returns all 16 bits of the selected word.
- R4: A read with byte mode 1 returns the selected half on its own lane (bits 15:8 for the high half, bits 7:0 for the low half), and the other lane reads as zero.
- R5: Read data is sampled on the synchronized leading edge of the strobe. The output enable and the data become valid on the third rising clock edge after the strobe rises, and not before.
- R6: The output enable is high only while chip select, read direction and the synchronized strobe are all asserted. It drops on the third rising clock edge after the strobe falls.
- R7: A word write stores all 16 bits. A byte write stores only the addressed half, taken from that half's own lane, and leaves the other half unchanged.
- R8: A write to word 1, in either half, clears transmit buffer empty. A pulse on the transmitter's take input sets it.
- R9: On the strobe's trailing edge, a completed read of word 0 clears receive data available for a low-byte read and receive status available for a high-byte read. A word read clears both.
- R10: Writes to word 3 and accesses made with chip select low change no register.
- R11: A receive data load or receive status load pulse stores the engine's byte and sets the matching available flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address; bits [2:1] word, bit 0 high half |
| bus_ce | input | 1 | Chip select, active high |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_strobe | input | 1 | Asynchronous data bus strobe, active high |
| db_in | input | 16 | Data bus input lanes |
| db_out | output | 16 | Data bus output lanes |
| db_oe | output | 1 | Data bus output enable |
| rx_data_in | input | 8 | Received byte from the receiver |
| rx_data_load | input | 1 | Load pulse for the received byte |
| rx_stat_in | input | 8 | Receive status byte from the receiver |
| rx_stat_load | input | 1 | Load pulse for the status byte |
| tx_taken | input | 1 | Transmitter has taken the transmit word |
| tx_data | output | 16 | Transmit word to the transmitter |
| tx_empty | output | 1 | Transmit buffer empty flag |
| ctl_word | output | 16 | Control word to the engines |
| rx_data_avail | output | 1 | Receive data available flag |
| rx_stat_avail | output | 1 | Receive status available flag |

## Verification
The bench uses the default parameters: 8-bit lanes, giving a 16-bit bus, and a two-stage synchronizer. Two lanes are enough to drive both the upper and the lower byte-steering paths. They also let the bench check that a byte write leaves the other half unchanged. With two synchronizer stages, the fixed three-edge latency from strobe to output is short enough to be counted and checked on both edges of the strobe. The flag word fits in the low lane, so the bench can read all three flags through the bus and compare them with the flag outputs.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int ADDR_W = 3;
  localparam int WSEL_W = ADDR_W - 1;
  localparam int LANES  = 2;

  typedef enum logic [WSEL_W-1:0] {
    WORD_RX   = 2'd0,
    WORD_TX   = 2'd1,
    WORD_CTL  = 2'd2,
    WORD_STAT = 2'd3
  } word_e;

  typedef struct packed {
    logic              sel;
    logic              wr;
    logic              bmode;
    logic [ADDR_W-1:0] addr;
  } acc_t;

  function automatic logic [LANES-1:0] lane_en(input logic bmode, input logic hi);
    if (!bmode) return '1;
    return hi ? 2'b10 : 2'b01;
  endfunction

  function automatic word_e word_of(input logic [ADDR_W-1:0] a);
    return word_e'(a[ADDR_W-1:1]);
  endfunction
endpackage

// File: rtl/hbi_strobe_sync.sv
module hbi_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic level,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], strobe_in};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs
  import hbi_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  word_e             wr_word,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [DW-1:0]     wr_data,
  input  logic              clr_rxd,
  input  logic              clr_rxs,
  input  logic [LANE_W-1:0] rx_data_in,
  input  logic              rx_data_load,
  input  logic [LANE_W-1:0] rx_stat_in,
  input  logic              rx_stat_load,
  input  logic              tx_taken,
  output logic [DW-1:0]     tx_q,
  output logic [DW-1:0]     ctl_q,
  output logic [DW-1:0]     rx_q,
  output logic              rxd_avail,
  output logic              rxs_avail,
  output logic              tx_empty
);
  logic tx_hit, ctl_hit;
  assign tx_hit  = wr_en && (wr_word == WORD_TX);
  assign ctl_hit = wr_en && (wr_word == WORD_CTL);

  // per-lane write enables for the two host-writable words
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        tx_q[l*LANE_W +: LANE_W]  <= '0;
        ctl_q[l*LANE_W +: LANE_W] <= '0;
      end else begin
        if (tx_hit && wr_lanes[l])  tx_q[l*LANE_W +: LANE_W]  <= wr_data[l*LANE_W +: LANE_W];
        if (ctl_hit && wr_lanes[l]) ctl_q[l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  // receive word: low lane data, high lane status, filled by the engine
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else begin
      if (rx_data_load) rx_q[LANE_W-1:0]    <= rx_data_in;
      if (rx_stat_load) rx_q[DW-1:LANE_W]   <= rx_stat_in;
    end
  end

  // flags: an engine event in the same cycle wins over a host clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_avail <= 1'b0;
      rxs_avail <= 1'b0;
      tx_empty  <= 1'b0;
    end else begin
      if (rx_data_load)  rxd_avail <= 1'b1;
      else if (clr_rxd)  rxd_avail <= 1'b0;
      if (rx_stat_load)  rxs_avail <= 1'b1;
      else if (clr_rxs)  rxs_avail <= 1'b0;
      if (tx_taken)      tx_empty  <= 1'b1;
      else if (tx_hit)   tx_empty  <= 1'b0;
    end
  end
endmodule

// File: rtl/hbi_read_mux.sv
module hbi_read_mux
  import hbi_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  word_e            sel_word,
  input  logic [LANES-1:0] sel_lanes,
  input  logic [DW-1:0]    rx_q,
  input  logic [DW-1:0]    tx_q,
  input  logic [DW-1:0]    ctl_q,
  input  logic [DW-1:0]    stat_q,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] full;

  always_comb begin
    unique case (sel_word)
      WORD_RX:   full = rx_q;
      WORD_TX:   full = tx_q;
      WORD_CTL:  full = ctl_q;
      default:   full = stat_q;
    endcase
  end

  // lanes not addressed by a byte read are forced to zero
  for (genvar l = 0; l < LANES; l++) begin : g_steer
    assign rd_data[l*LANE_W +: LANE_W] = sel_lanes[l] ? full[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/hbi_bus_if.sv
module hbi_bus_if
  import hbi_pkg::*;
#(
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ce,
  input  logic              bus_byte,
  input  logic              bus_wr,
  input  logic              bus_strobe,
  input  logic [DW-1:0]     db_in,
  output logic [DW-1:0]     db_out,
  output logic              db_oe,
  input  logic [LANE_W-1:0] rx_data_in,
  input  logic              rx_data_load,
  input  logic [LANE_W-1:0] rx_stat_in,
  input  logic              rx_stat_load,
  input  logic              tx_taken,
  output logic [DW-1:0]     tx_data,
  output logic              tx_empty,
  output logic [DW-1:0]     ctl_word,
  output logic              rx_data_avail,
  output logic              rx_stat_avail
);
  logic stb_lvl, stb_rise, stb_fall;

  hbi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .strobe_in (bus_strobe),
    .level     (stb_lvl),
    .rise      (stb_rise),
    .fall      (stb_fall)
  );

  word_e            cur_word;
  logic [LANES-1:0] cur_lanes;
  logic             wr_fire, rd_fire;

  assign cur_word  = word_of(bus_addr);
  assign cur_lanes = lane_en(bus_byte, bus_addr[0]);
  assign wr_fire   = stb_rise & bus_ce & bus_wr;
  assign rd_fire   = stb_rise & bus_ce & ~bus_wr;

  // access descriptor held from leading edge to trailing edge
  acc_t acc_q;
  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (stb_rise) acc_q <= '{sel: bus_ce, wr: bus_wr, bmode: bus_byte, addr: bus_addr};
  end

  logic             acc_rd_rx;
  logic [LANES-1:0] acc_lanes;
  logic             clr_rxd, clr_rxs;

  assign acc_rd_rx = acc_q.sel && !acc_q.wr && (word_of(acc_q.addr) == WORD_RX);
  assign acc_lanes = lane_en(acc_q.bmode, acc_q.addr[0]);
  assign clr_rxd   = stb_fall && acc_rd_rx && acc_lanes[0];
  assign clr_rxs   = stb_fall && acc_rd_rx && acc_lanes[1];

  logic [DW-1:0] rx_q, stat_q, rd_data;
  logic          rxd_avail, rxs_avail, txe;

  hbi_regs #(.LANE_W(LANE_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_fire),
    .wr_word      (cur_word),
    .wr_lanes     (cur_lanes),
    .wr_data      (db_in),
    .clr_rxd      (clr_rxd),
    .clr_rxs      (clr_rxs),
    .rx_data_in   (rx_data_in),
    .rx_data_load (rx_data_load),
    .rx_stat_in   (rx_stat_in),
    .rx_stat_load (rx_stat_load),
    .tx_taken     (tx_taken),
    .tx_q         (tx_data),
    .ctl_q        (ctl_word),
    .rx_q         (rx_q),
    .rxd_avail    (rxd_avail),
    .rxs_avail    (rxs_avail),
    .tx_empty     (txe)
  );

  assign stat_q = {{(DW-3){1'b0}}, txe, rxs_avail, rxd_avail};

  hbi_read_mux #(.LANE_W(LANE_W)) u_mux (
    .sel_word  (cur_word),
    .sel_lanes (cur_lanes),
    .rx_q      (rx_q),
    .tx_q      (tx_data),
    .ctl_q     (ctl_word),
    .stat_q    (stat_q),
    .rd_data   (rd_data)
  );

  // registered bus outputs
  logic [DW-1:0] db_out_q;
  logic          db_oe_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      db_out_q <= '0;
      db_oe_q  <= 1'b0;
    end else begin
      if (rd_fire) db_out_q <= rd_data;
      db_oe_q <= bus_ce & ~bus_wr & stb_lvl;
    end
  end

  assign db_out        = db_out_q;
  assign db_oe         = db_oe_q;
  assign tx_empty      = txe;
  assign rx_data_avail = rxd_avail;
  assign rx_stat_avail = rxs_avail;
endmodule

// File: rtl/hbi_bus_checker.sv
module hbi_bus_checker
  import hbi_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ce,
  input logic              bus_byte,
  input logic              bus_wr,
  input logic [DW-1:0]     db_out,
  input logic              db_oe,
  input logic              rx_data_load,
  input logic              rx_stat_load,
  input logic              tx_taken,
  input logic [DW-1:0]     tx_data,
  input logic [DW-1:0]     ctl_word,
  input logic              tx_empty,
  input logic              rx_data_avail,
  input logic              rx_stat_avail,
  input logic              stb_lvl,
  input logic              stb_rise,
  input logic              stb_fall,
  input acc_t              acc_q
);
  localparam int HW = DW / 2;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (db_out == '0 && !db_oe && !tx_empty && !rx_data_avail &&
             !rx_stat_avail && tx_data == '0 && ctl_word == '0));

  a_r6_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
    db_oe |-> $past(bus_ce && !bus_wr && stb_lvl));

  a_r5_oe_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(db_oe) |-> $past(stb_lvl));

  a_r4_hi_read_low_zero: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && bus_ce && !bus_wr && bus_byte && bus_addr[0]) |=> db_out[HW-1:0] == '0);

  a_r4_lo_read_high_zero: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && bus_ce && !bus_wr && bus_byte && !bus_addr[0]) |=> db_out[DW-1:HW] == '0);

  a_r8_tx_write_clears: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && bus_ce && bus_wr && bus_addr[ADDR_W-1:1] == 2'd1 && !tx_taken) |=> !tx_empty);

  a_r8_taken_sets: assert property (@(posedge clk) disable iff (rst)
    tx_taken |=> tx_empty);

  a_r9_rx_low_clear: assert property (@(posedge clk) disable iff (rst)
    (stb_fall && acc_q.sel && !acc_q.wr && acc_q.addr[ADDR_W-1:1] == 2'd0 &&
     !(acc_q.bmode && acc_q.addr[0]) && !rx_data_load) |=> !rx_data_avail);

  a_r9_rx_high_clear: assert property (@(posedge clk) disable iff (rst)
    (stb_fall && acc_q.sel && !acc_q.wr && acc_q.addr[ADDR_W-1:1] == 2'd0 &&
     !(acc_q.bmode && !acc_q.addr[0]) && !rx_stat_load) |=> !rx_stat_avail);

  a_r11_loads_set: assert property (@(posedge clk) disable iff (rst)
    (rx_data_load && rx_stat_load) |=> (rx_data_avail && rx_stat_avail));

  a_r10_no_ce_no_write: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && !bus_ce) |=> ($stable(ctl_word) && $stable(tx_data)));
endmodule

bind hbi_bus_if hbi_bus_checker #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_ce        (bus_ce),
  .bus_byte      (bus_byte),
  .bus_wr        (bus_wr),
  .db_out        (db_out),
  .db_oe         (db_oe),
  .rx_data_load  (rx_data_load),
  .rx_stat_load  (rx_stat_load),
  .tx_taken      (tx_taken),
  .tx_data       (tx_data),
  .ctl_word      (ctl_word),
  .tx_empty      (tx_empty),
  .rx_data_avail (rx_data_avail),
  .rx_stat_avail (rx_stat_avail),
  .stb_lvl       (stb_lvl),
  .stb_rise      (stb_rise),
  .stb_fall      (stb_fall),
  .acc_q         (acc_q)
);

// File: tb/tb_hbi_bus_if.sv
module tb_hbi_bus_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_ce = 1'b0, bus_byte = 1'b0, bus_wr = 1'b0, bus_strobe = 1'b0;
  logic [15:0] db_in = '0;
  logic [15:0] db_out;
  logic        db_oe;
  logic [7:0]  rx_data_in = '0, rx_stat_in = '0;
  logic        rx_data_load = 1'b0, rx_stat_load = 1'b0, tx_taken = 1'b0;
  logic [15:0] tx_data, ctl_word;
  logic        tx_empty, rx_data_avail, rx_stat_avail;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hbi_bus_if dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_ce(bus_ce), .bus_byte(bus_byte),
    .bus_wr(bus_wr), .bus_strobe(bus_strobe), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
    .rx_data_in(rx_data_in), .rx_data_load(rx_data_load), .rx_stat_in(rx_stat_in),
    .rx_stat_load(rx_stat_load), .tx_taken(tx_taken), .tx_data(tx_data), .tx_empty(tx_empty),
    .ctl_word(ctl_word), .rx_data_avail(rx_data_avail), .rx_stat_avail(rx_stat_avail)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one complete strobe cycle; samples data/oe during and oe after
  task automatic bus_cycle(input logic wr, input logic ce, input logic [2:0] a,
                           input logic bm, input logic [15:0] wd,
                           output logic [15:0] rd, output logic oe_in, output logic oe_after);
    @(negedge clk);
    bus_wr = wr; bus_ce = ce; bus_addr = a; bus_byte = bm; db_in = wd; bus_strobe = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd = db_out; oe_in = db_oe;
    bus_strobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    oe_after = db_oe;
    bus_ce = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic        ce;
    logic [2:0]  addr;
    logic        bmode;
    logic [15:0] wdata;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 3'd4, 1'b0, 16'hA55A, 16'h0000}, // R7 word write control
    '{1'b0, 1'b1, 3'd4, 1'b0, 16'h0000, 16'hA55A}, // R3 word read
    '{1'b1, 1'b1, 3'd5, 1'b1, 16'h3C00, 16'h0000}, // R7 high byte write from high lane
    '{1'b0, 1'b1, 3'd4, 1'b1, 16'h0000, 16'h005A}, // R4 low byte read
    '{1'b0, 1'b1, 3'd5, 1'b1, 16'h0000, 16'h3C00}, // R4 high byte read
    '{1'b1, 1'b1, 3'd4, 1'b1, 16'hFF11, 16'h0000}, // R7 low byte write, high lane ignored
    '{1'b0, 1'b1, 3'd4, 1'b0, 16'h0000, 16'h3C11}, // R7 both halves
    '{1'b1, 1'b0, 3'd4, 1'b0, 16'h0000, 16'h0000}, // R10 write without chip select
    '{1'b0, 1'b1, 3'd4, 1'b0, 16'h0000, 16'h3C11}, // R10 unchanged
    '{1'b1, 1'b1, 3'd2, 1'b0, 16'h1234, 16'h0000}, // R2 transmit word write
    '{1'b0, 1'b1, 3'd2, 1'b0, 16'h0000, 16'h1234}, // R3 transmit word read
    '{1'b0, 1'b1, 3'd3, 1'b1, 16'h0000, 16'h1200}, // R4 transmit high byte
    '{1'b1, 1'b1, 3'd6, 1'b0, 16'hFFFF, 16'h0000}, // R10 write to flag word
    '{1'b0, 1'b1, 3'd6, 1'b0, 16'h0000, 16'h0000}  // R2 flag word all clear
  };

  initial begin
    logic [15:0] rd;
    logic        oe_in, oe_after;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 db_out", db_out, 16'h0);
    chk("R1 db_oe", {15'b0, db_oe}, 16'h0);
    chk("R1 flags", {13'b0, tx_empty, rx_stat_avail, rx_data_avail}, 16'h0);
    chk("R1 tx_data", tx_data, 16'h0);
    chk("R1 ctl_word", ctl_word, 16'h0);

    for (int i = 0; i < NV; i++) begin
      bus_cycle(VECS[i].wr, VECS[i].ce, VECS[i].addr, VECS[i].bmode, VECS[i].wdata,
                rd, oe_in, oe_after);
      if (!VECS[i].wr) begin
        chk($sformatf("R3/R4/R7/R10 vec %0d data", i), rd, VECS[i].exp);
        chk($sformatf("R6 vec %0d oe during read", i), {15'b0, oe_in}, 16'h1);
      end else begin
        chk($sformatf("R6 vec %0d oe on write", i), {15'b0, oe_in}, 16'h0);
      end
      chk($sformatf("R6 vec %0d oe after strobe", i), {15'b0, oe_after}, 16'h0);
    end
    chk("R7 ctl_word port", ctl_word, 16'h3C11);

    // R8 take pulse sets empty, read through the flag word (R2)
    @(negedge clk); tx_taken = 1'b1;
    @(negedge clk); tx_taken = 1'b0;
    chk("R8 empty set", {15'b0, tx_empty}, 16'h1);
    bus_cycle(1'b0, 1'b1, 3'd6, 1'b0, 16'h0, rd, oe_in, oe_after);
    chk("R2 flag word empty", rd, 16'h0004);
    bus_cycle(1'b1, 1'b1, 3'd3, 1'b1, 16'hAB00, rd, oe_in, oe_after);
    chk("R8 empty cleared by high write", {15'b0, tx_empty}, 16'h0);
    chk("R7 tx high byte only", tx_data, 16'hAB34);

    // R11 engine loads
    @(negedge clk);
    rx_data_in = 8'h5E; rx_stat_in = 8'hC3; rx_data_load = 1'b1; rx_stat_load = 1'b1;
    @(negedge clk);
    rx_data_load = 1'b0; rx_stat_load = 1'b0;
    chk("R11 flags set", {14'b0, rx_stat_avail, rx_data_avail}, 16'h3);
    bus_cycle(1'b0, 1'b1, 3'd6, 1'b0, 16'h0, rd, oe_in, oe_after);
    chk("R2 flag word rx", rd, 16'h0003);

    // R9 trailing-edge clears
    bus_cycle(1'b0, 1'b1, 3'd0, 1'b1, 16'h0, rd, oe_in, oe_after);
    chk("R4 rx low byte", rd, 16'h005E);
    chk("R9 low read clears data flag only", {14'b0, rx_stat_avail, rx_data_avail}, 16'h2);
    bus_cycle(1'b0, 1'b1, 3'd1, 1'b1, 16'h0, rd, oe_in, oe_after);
    chk("R4 rx high byte", rd, 16'hC300);
    chk("R9 high read clears status flag", {14'b0, rx_stat_avail, rx_data_avail}, 16'h0);
    @(negedge clk);
    rx_data_in = 8'h81; rx_stat_in = 8'h07; rx_data_load = 1'b1; rx_stat_load = 1'b1;
    @(negedge clk);
    rx_data_load = 1'b0; rx_stat_load = 1'b0;
    bus_cycle(1'b0, 1'b1, 3'd0, 1'b0, 16'h0, rd, oe_in, oe_after);
    chk("R3 rx word", rd, 16'h0781);
    chk("R9 word read clears both", {14'b0, rx_stat_avail, rx_data_avail}, 16'h0);

    // R5 latency of the leading edge
    @(negedge clk);
    bus_wr = 1'b0; bus_ce = 1'b1; bus_addr = 3'd4; bus_byte = 1'b0; bus_strobe = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 no oe after two edges", {15'b0, db_oe}, 16'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 oe after three edges", {15'b0, db_oe}, 16'h1);
    chk("R5 data after three edges", db_out, 16'h3C11);
    bus_strobe = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 oe still high two edges after fall", {15'b0, db_oe}, 16'h1);
    @(posedge clk);
    @(negedge clk);
    chk("R6 oe low three edges after fall", {15'b0, db_oe}, 16'h0);
    bus_ce = 1'b0;

    // R6 read without chip select never drives
    bus_cycle(1'b0, 1'b0, 3'd4, 1'b0, 16'h0, rd, oe_in, oe_after);
    chk("R6 no oe without chip select", {15'b0, oe_in}, 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule